// File: doc/BRIEF.md
# DDR3 Write Burst Data Sequencer

This block sits on the controller side of a DDR3 memory interface. It turns each write request into a timed data burst on the memory data pins. A request carries a full eight-beat payload, one mask bit per byte lane per beat, and a flag that asks for a chopped four-beat burst. Requests enter through a valid/ready stream. The producer holds `in_valid` and the payload steady until it sees `in_ready` high at a rising clock edge. `in_ready` goes low only while two requests are waiting to be issued.

The block decides when each queued request goes out as a WRITE command and reports that on `cmd_fire`. It then waits the write latency: the additive latency plus the CAS write latency, both taken from mode-register settings. After that it drives DQ, DM and DQS. Each clock cycle is modelled as two half-cycle slots. `dq_rise` and `dm_rise` belong to the DQS rising edge at the start of the cycle, and `dq_fall` and `dm_fall` to the falling edge at mid-cycle. The DQS pin is described per half-cycle by `dqs_oe` and `dqs_lvl`, where bit 0 is the first half. The PHY tri-states each pad whenever its enable is low.

Commands issued four clocks apart produce one unbroken data stream. Settings are taken in only while the block is idle.

Top module: `ddr3_wr_seq`

## Requirements
- R1: After reset `in_ready` is 1, and `cmd_fire`, `dq_oe` and `dqs_oe` are 0.
- R2: Write latency WL = AL + CWL. AL is 0 for `cfg_al_sel`=0 or 3, CL-1 for 1, and CL-2 for 2, with CL = `cfg_cl` (5..11) and CWL = `cfg_cwl` (5..8). The settings are loaded only in a cycle where no request is queued, no burst is pending and DQS is undriven.
- R3: If `cmd_fire` is high in cycle n, the command is issued at the edge that ends cycle n, and its first data cycle is cycle n+1+WL.
- R4: Beat j of `in_data` is bits [16j+15:16j]. In data cycle i of a burst, `dq_rise` carries beat 2i and `dq_fall` carries beat 2i+1.
- R5: Mask bits [2j+1:2j] of `in_mask` belong to beat j. They appear on `dm_rise`/`dm_fall` with the beat they belong to; a 1 marks that byte as not written.
- R6: In the cycle before a data cycle that does not follow another data cycle, `dqs_oe`=2'b11 and `dqs_lvl`=2'b00 (full-cycle preamble).
- R7: In the cycle after the last data cycle, if no data follows in the next two cycles, `dqs_oe`=2'b01 and `dqs_lvl`=2'b00 (first half driven low, then released).
- R8: In every data cycle `dq_oe`=1, `dqs_oe`=2'b11 and `dqs_lvl`=2'b01 (rising at cycle start, falling at mid-cycle).
- R9: Commands issued four cycles apart give back-to-back data cycles with no preamble or postamble between them.
- R10: The burst kind comes from `cfg_bl_sel`: 0 is always eight beats, 1 is always four beats, and 2 or 3 takes `in_bc4` per request. `cmd_bc4` shows the chosen kind while `cmd_fire` is high. A four-beat burst drives beats 0..3 in two data cycles, and beats 4..7 are never driven.
- R11: `cmd_fire` pulses are at least four cycles apart. A waiting request fires in the first cycle where this spacing allows it, which is at the earliest the cycle after it was accepted. Requests fire in acceptance order.
- R12: `in_ready` is 0 exactly when two accepted requests are waiting to fire. Outside data cycles `dq_oe` is 0 and `dq_rise`, `dq_fall`, `dm_rise` and `dm_fall` are 0.
- R13: Once an eight-beat burst starts it spans four consecutive data cycles and is never cut short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_al_sel | input | 2 | Additive latency select: 0 off, 1 CL-1, 2 CL-2, 3 off |
| cfg_cl | input | 4 | CAS latency used to derive AL |
| cfg_cwl | input | 4 | CAS write latency |
| cfg_bl_sel | input | 2 | Burst kind: 0 eight beats, 1 four beats, 2/3 per request |
| in_valid | input | 1 | Write request valid |
| in_ready | output | 1 | Request accepted at the edge when high with `in_valid` |
| in_bc4 | input | 1 | Per-request four-beat flag, used when `cfg_bl_sel` is 2 or 3 |
| in_data | input | 128 | Eight beats of 16 bits, beat 0 in the low bits |
| in_mask | input | 16 | Two byte-mask bits per beat, 1 = masked |
| cmd_fire | output | 1 | Request issued as a WRITE at the edge ending this cycle |
| cmd_bc4 | output | 1 | Chosen burst kind of the issued command |
| dq_oe | output | 1 | DQ and DM drive enable for this cycle |
| dq_rise | output | 16 | Data on the DQS rising edge |
| dq_fall | output | 16 | Data on the DQS falling edge |
| dm_rise | output | 2 | Mask on the DQS rising edge |
| dm_fall | output | 2 | Mask on the DQS falling edge |
| dqs_oe | output | 2 | DQS drive enable per half-cycle, bit 0 first half |
| dqs_lvl | output | 2 | DQS level per half-cycle, bit 0 first half |

## Verification
Results fall due at fixed points. `in_ready` and `cmd_fire` reflect state registered at the previous edge, so both are due in the same cycle as the queue contents that decide them. The data of a command that fires in cycle n is due in cycle n+1+WL, its preamble one cycle earlier, and its postamble one cycle after its last data cycle. The bench model records each observed fire in a timeline indexed by absolute cycle, using its own copy of WL latched under the idle rule. Every output is sampled at the falling clock edge, away from the edge that updates it, and compared against that timeline in the same cycle.

// File: rtl/ddr3w_pkg.sv
package ddr3w_pkg;

  typedef enum logic [1:0] {
    AL_ZERO      = 2'd0,
    AL_CL_MINUS1 = 2'd1,
    AL_CL_MINUS2 = 2'd2,
    AL_SPARE     = 2'd3
  } al_sel_e;

  typedef enum logic [1:0] {
    BLK_FIXED8  = 2'd0,
    BLK_FIXED4  = 2'd1,
    BLK_PERCMD  = 2'd2,
    BLK_PERCMD2 = 2'd3
  } blk_sel_e;

  typedef enum logic [1:0] {
    STB_OFF  = 2'd0,
    STB_POST = 2'd1,
    STB_PRE  = 2'd2,
    STB_DATA = 2'd3
  } stb_e;

  // write latency in clocks from the raw setting fields
  function automatic int calc_wl(logic [1:0] al_sel, logic [3:0] cl, logic [3:0] cwl);
    int al;
    case (al_sel)
      AL_CL_MINUS1: al = int'(cl) - 1;
      AL_CL_MINUS2: al = int'(cl) - 2;
      default:      al = 0;
    endcase
    return al + int'(cwl);
  endfunction

endpackage

// File: rtl/ddr3w_req_fifo.sv
module ddr3w_req_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_valid,
  output logic         wr_ready,
  input  logic [W-1:0] wr_data,
  output logic         rd_valid,
  output logic [W-1:0] rd_data,
  input  logic         rd_take
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          wr_en, rd_en;

  function automatic logic [PW-1:0] step(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign wr_ready = (count != CW'(DEPTH));
  assign rd_valid = (count != '0);
  assign wr_en    = wr_valid & wr_ready;
  assign rd_en    = rd_take & rd_valid;
  assign rd_data  = mem[rd_ptr];

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && wr_ptr == PW'(e)) mem[e] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= step(wr_ptr);
      if (rd_en) rd_ptr <= step(rd_ptr);
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/ddr3w_issue.sv
module ddr3w_issue
  import ddr3w_pkg::*;
#(
  parameter int WL_MAX = 18,
  parameter int CCD    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idle,
  input  logic [1:0] cfg_al_sel,
  input  logic [3:0] cfg_cl,
  input  logic [3:0] cfg_cwl,
  input  logic [1:0] cfg_bl_sel,
  input  logic       head_valid,
  input  logic       head_bc4,
  input  logic       room,
  output logic       fire,
  output logic       fire_bc4,
  output logic       launch,
  output logic       launch_soon,
  output logic       pending
);
  localparam int WLW = $clog2(WL_MAX + 1);
  localparam int GW  = (CCD > 2) ? $clog2(CCD) : 1;

  logic [WLW-1:0]  wl_q;
  blk_sel_e        blk_q;
  logic [WL_MAX-1:0] sr_q, sr_n;
  logic [GW-1:0]   gap_q;
  int              wl_raw, wl_lim;

  always_comb begin
    wl_raw = calc_wl(cfg_al_sel, cfg_cl, cfg_cwl);
    if (wl_raw < 2)           wl_lim = 2;
    else if (wl_raw > WL_MAX) wl_lim = WL_MAX;
    else                      wl_lim = wl_raw;
  end

  assign fire = head_valid & room & (gap_q == '0);

  always_comb begin
    case (blk_q)
      BLK_FIXED8: fire_bc4 = 1'b0;
      BLK_FIXED4: fire_bc4 = 1'b1;
      default:    fire_bc4 = head_bc4;
    endcase
  end

  // one-hot countdown: the fired bit walks to position 0 in WL-1 cycles
  always_comb begin
    sr_n = sr_q >> 1;
    for (int i = 0; i < WL_MAX; i++) begin
      if (fire && i == int'(wl_q) - 1) sr_n[i] = 1'b1;
    end
  end

  assign launch      = sr_q[0];
  assign launch_soon = sr_q[1];
  assign pending     = (sr_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wl_q  <= WLW'(5);
      blk_q <= BLK_FIXED8;
      sr_q  <= '0;
      gap_q <= '0;
    end else begin
      if (idle) begin
        wl_q  <= WLW'(wl_lim);
        blk_q <= blk_sel_e'(cfg_bl_sel);
      end
      sr_q <= sr_n;
      if (fire)              gap_q <= GW'(CCD - 1);
      else if (gap_q != '0)  gap_q <= gap_q - 1'b1;
    end
  end

endmodule

// File: rtl/ddr3w_beat_ser.sv
module ddr3w_beat_ser #(
  parameter int DQ_W  = 16,
  parameter int MW    = 2,
  parameter int BEATS = 8,
  parameter int DEPTH = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fire,
  input  logic                  fire_bc4,
  input  logic [DQ_W*BEATS-1:0] fire_data,
  input  logic [MW*BEATS-1:0]   fire_mask,
  input  logic                  launch,
  input  logic                  launch_soon,
  output logic                  room,
  output logic                  dq_oe,
  output logic [DQ_W-1:0]       dq_rise,
  output logic [DQ_W-1:0]       dq_fall,
  output logic [MW-1:0]         dm_rise,
  output logic [MW-1:0]         dm_fall,
  output logic                  dv_next,
  output logic                  dv_next2
);
  localparam int DW   = DQ_W * BEATS;
  localparam int KW   = MW * BEATS;
  localparam int CYC8 = BEATS / 2;
  localparam int CYC4 = BEATS / 4;
  localparam int LW   = $clog2(CYC8 + 1);
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW   = $clog2(DEPTH + 1);

  logic [DW-1:0] ring_d [DEPTH];
  logic [KW-1:0] ring_m [DEPTH];
  logic          ring_c [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] fill;
  logic [DW-1:0] sh_d;
  logic [KW-1:0] sh_m;
  logic [LW-1:0] left;

  function automatic logic [PW-1:0] step(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign room     = (fill != CW'(DEPTH));
  assign dq_oe    = (left != '0);
  assign dv_next  = launch | (left > LW'(1));
  assign dv_next2 = launch_soon | launch | (left > LW'(2));

  for (genvar e = 0; e < DEPTH; e++) begin : g_flight
    always_ff @(posedge clk) begin
      if (fire && wr_ptr == PW'(e)) begin
        ring_d[e] <= fire_data;
        ring_m[e] <= fire_mask;
        ring_c[e] <= fire_bc4;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (fire)   wr_ptr <= step(wr_ptr);
      if (launch) rd_ptr <= step(rd_ptr);
      case ({fire, launch})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left    <= '0;
      sh_d    <= '0;
      sh_m    <= '0;
      dq_rise <= '0;
      dq_fall <= '0;
      dm_rise <= '0;
      dm_fall <= '0;
    end else if (launch) begin
      left    <= ring_c[rd_ptr] ? LW'(CYC4) : LW'(CYC8);
      dq_rise <= ring_d[rd_ptr][0 +: DQ_W];
      dq_fall <= ring_d[rd_ptr][DQ_W +: DQ_W];
      dm_rise <= ring_m[rd_ptr][0 +: MW];
      dm_fall <= ring_m[rd_ptr][MW +: MW];
      sh_d    <= ring_d[rd_ptr] >> (2 * DQ_W);
      sh_m    <= ring_m[rd_ptr] >> (2 * MW);
    end else if (left > LW'(1)) begin
      left    <= left - 1'b1;
      dq_rise <= sh_d[0 +: DQ_W];
      dq_fall <= sh_d[DQ_W +: DQ_W];
      dm_rise <= sh_m[0 +: MW];
      dm_fall <= sh_m[MW +: MW];
      sh_d    <= sh_d >> (2 * DQ_W);
      sh_m    <= sh_m >> (2 * MW);
    end else begin
      left    <= '0;
      dq_rise <= '0;
      dq_fall <= '0;
      dm_rise <= '0;
      dm_fall <= '0;
    end
  end

endmodule

// File: rtl/ddr3w_strobe_gen.sv
module ddr3w_strobe_gen
  import ddr3w_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dv_now,
  input  logic       dv_next,
  input  logic       dv_next2,
  output logic [1:0] dqs_oe,
  output logic [1:0] dqs_lvl
);
  stb_e st_q, st_n;

  // data wins, then preamble (which swallows a pending postamble), then postamble
  always_comb begin
    if (dv_next)       st_n = STB_DATA;
    else if (dv_next2) st_n = STB_PRE;
    else if (dv_now)   st_n = STB_POST;
    else               st_n = STB_OFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= STB_OFF;
    else        st_q <= st_n;
  end

  always_comb begin
    case (st_q)
      STB_DATA: begin dqs_oe = 2'b11; dqs_lvl = 2'b01; end
      STB_PRE:  begin dqs_oe = 2'b11; dqs_lvl = 2'b00; end
      STB_POST: begin dqs_oe = 2'b01; dqs_lvl = 2'b00; end
      default:  begin dqs_oe = 2'b00; dqs_lvl = 2'b00; end
    endcase
  end

endmodule

// File: rtl/ddr3_wr_seq.sv
module ddr3_wr_seq
  import ddr3w_pkg::*;
#(
  parameter int DQ_W         = 16,
  parameter int BEATS        = 8,
  parameter int REQ_DEPTH    = 2,
  parameter int FLIGHT_DEPTH = 8,
  parameter int CL_MAX       = 11,
  parameter int CWL_MAX      = 8,
  parameter int CCD          = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              cfg_al_sel,
  input  logic [3:0]              cfg_cl,
  input  logic [3:0]              cfg_cwl,
  input  logic [1:0]              cfg_bl_sel,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic                    in_bc4,
  input  logic [DQ_W*BEATS-1:0]   in_data,
  input  logic [DQ_W/8*BEATS-1:0] in_mask,
  output logic                    cmd_fire,
  output logic                    cmd_bc4,
  output logic                    dq_oe,
  output logic [DQ_W-1:0]         dq_rise,
  output logic [DQ_W-1:0]         dq_fall,
  output logic [DQ_W/8-1:0]       dm_rise,
  output logic [DQ_W/8-1:0]       dm_fall,
  output logic [1:0]              dqs_oe,
  output logic [1:0]              dqs_lvl
);
  localparam int MW     = DQ_W / 8;
  localparam int DW     = DQ_W * BEATS;
  localparam int KW     = MW * BEATS;
  localparam int QW     = DW + KW + 1;
  localparam int WL_MAX = (CL_MAX - 1) + CWL_MAX;

  logic [QW-1:0] head;
  logic          head_valid, room, launch, launch_soon, pending;
  logic          dv_next, dv_next2, idle;

  ddr3w_req_fifo #(.W(QW), .DEPTH(REQ_DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (in_valid),
    .wr_ready (in_ready),
    .wr_data  ({in_bc4, in_mask, in_data}),
    .rd_valid (head_valid),
    .rd_data  (head),
    .rd_take  (cmd_fire)
  );

  assign idle = ~head_valid & ~pending & ~dq_oe & (dqs_oe == 2'b00);

  ddr3w_issue #(.WL_MAX(WL_MAX), .CCD(CCD)) u_issue (
    .clk         (clk),
    .rst_n       (rst_n),
    .idle        (idle),
    .cfg_al_sel  (cfg_al_sel),
    .cfg_cl      (cfg_cl),
    .cfg_cwl     (cfg_cwl),
    .cfg_bl_sel  (cfg_bl_sel),
    .head_valid  (head_valid),
    .head_bc4    (head[QW-1]),
    .room        (room),
    .fire        (cmd_fire),
    .fire_bc4    (cmd_bc4),
    .launch      (launch),
    .launch_soon (launch_soon),
    .pending     (pending)
  );

  ddr3w_beat_ser #(.DQ_W(DQ_W), .MW(MW), .BEATS(BEATS), .DEPTH(FLIGHT_DEPTH)) u_ser (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire        (cmd_fire),
    .fire_bc4    (cmd_bc4),
    .fire_data   (head[DW-1:0]),
    .fire_mask   (head[DW +: KW]),
    .launch      (launch),
    .launch_soon (launch_soon),
    .room        (room),
    .dq_oe       (dq_oe),
    .dq_rise     (dq_rise),
    .dq_fall     (dq_fall),
    .dm_rise     (dm_rise),
    .dm_fall     (dm_fall),
    .dv_next     (dv_next),
    .dv_next2    (dv_next2)
  );

  ddr3w_strobe_gen u_stb (
    .clk      (clk),
    .rst_n    (rst_n),
    .dv_now   (dq_oe),
    .dv_next  (dv_next),
    .dv_next2 (dv_next2),
    .dqs_oe   (dqs_oe),
    .dqs_lvl  (dqs_lvl)
  );

endmodule

// File: rtl/ddr3w_checker.sv
module ddr3w_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_fire,
  input logic       dq_oe,
  input logic [1:0] dqs_oe,
  input logic [1:0] dqs_lvl
);

  assert_data_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (dqs_oe == 2'b11 && dqs_lvl == 2'b01));

  assert_preamble_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> ($past(dqs_oe) == 2'b11 && $past(dqs_lvl) == 2'b00));

  assert_postamble_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dq_oe) |-> (dqs_oe[0] && dqs_lvl == 2'b00));

  assert_spacing1_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |=> !cmd_fire);

  assert_spacing2_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |-> ##2 !cmd_fire);

  assert_spacing3_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |-> ##3 !cmd_fire);

  assert_no_cut_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |=> dq_oe);

endmodule

bind ddr3_wr_seq ddr3w_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_fire (cmd_fire),
  .dq_oe    (dq_oe),
  .dqs_oe   (dqs_oe),
  .dqs_lvl  (dqs_lvl)
);

// File: tb/test_ddr3_wr_seq.sv
`timescale 1ns/1ps
module test_ddr3_wr_seq;
  localparam int DQ_W = 16;
  localparam int MW   = 2;
  localparam int DW   = 128;
  localparam int KW   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_al_sel = 2'd0;
  logic [3:0] cfg_cl = 4'd6;
  logic [3:0] cfg_cwl = 4'd5;
  logic [1:0] cfg_bl_sel = 2'd0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic in_bc4 = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [KW-1:0] in_mask = '0;
  logic cmd_fire, cmd_bc4, dq_oe;
  logic [DQ_W-1:0] dq_rise, dq_fall;
  logic [MW-1:0] dm_rise, dm_fall;
  logic [1:0] dqs_oe, dqs_lvl;

  always #4 clk = ~clk;

  ddr3_wr_seq i_ddr3_wr_seq (
    .clk(clk), .rst_n(rst_n), .cfg_al_sel(cfg_al_sel), .cfg_cl(cfg_cl),
    .cfg_cwl(cfg_cwl), .cfg_bl_sel(cfg_bl_sel), .in_valid(in_valid),
    .in_ready(in_ready), .in_bc4(in_bc4), .in_data(in_data), .in_mask(in_mask),
    .cmd_fire(cmd_fire), .cmd_bc4(cmd_bc4), .dq_oe(dq_oe), .dq_rise(dq_rise),
    .dq_fall(dq_fall), .dm_rise(dm_rise), .dm_fall(dm_fall),
    .dqs_oe(dqs_oe), .dqs_lvl(dqs_lvl)
  );

  typedef struct {
    logic [DW-1:0] d;
    logic [KW-1:0] m;
    logic          bc4;
  } req_t;

  req_t q[$];
  bit              exp_dv [64];
  logic [DQ_W-1:0] exp_r  [64];
  logic [DQ_W-1:0] exp_f  [64];
  logic [MW-1:0]   exp_mr [64];
  logic [MW-1:0]   exp_mf [64];

  int  vecs = 0, errs = 0, cyc = 0, last_fire = -100;
  int  m_wl = 5;
  int  m_bl = 0;
  bit  started = 0, done = 0;

  task automatic chk(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s cycle %0d actual=%0h expected=%0h", req, what, cyc, act, exp);
    end
  endtask

  function automatic int model_wl(logic [1:0] sel, logic [3:0] cl, logic [3:0] cwl);
    int al = 0;
    if (sel == 2'd1) al = int'(cl) - 1;
    if (sel == 2'd2) al = int'(cl) - 2;
    return al + int'(cwl);
  endfunction

  always @(negedge clk) begin
    if (rst_n && started && !done) begin
      int s, nx, pv, qn;
      bit idle, efire;
      s  = cyc % 64;
      nx = (cyc + 1) % 64;
      pv = (cyc + 63) % 64;
      qn = q.size();

      idle = (qn == 0);
      for (int k = -1; k < 26; k++) if (exp_dv[(cyc + 64 + k) % 64]) idle = 0;

      chk(in_ready == (qn < 2), "R12", "in_ready", DW'(in_ready), DW'(qn < 2));
      efire = (qn > 0) && (cyc - last_fire >= 4);
      chk(cmd_fire == efire, "R11", "cmd_fire", DW'(cmd_fire), DW'(efire));

      chk(dq_oe == exp_dv[s], "R13", "dq_oe (R3 latency)", DW'(dq_oe), DW'(exp_dv[s]));
      if (exp_dv[s]) begin
        chk(dq_rise == exp_r[s] && dq_fall == exp_f[s], "R4", "dq rise/fall",
            DW'({dq_rise, dq_fall}), DW'({exp_r[s], exp_f[s]}));
        chk(dm_rise == exp_mr[s] && dm_fall == exp_mf[s], "R5", "dm rise/fall",
            DW'({dm_rise, dm_fall}), DW'({exp_mr[s], exp_mf[s]}));
        chk(dqs_oe == 2'b11 && dqs_lvl == 2'b01, exp_dv[pv] ? "R9" : "R8", "dqs data",
            DW'({dqs_oe, dqs_lvl}), DW'(4'b1101));
      end else begin
        chk(dq_rise == '0 && dq_fall == '0 && dm_rise == '0 && dm_fall == '0, "R12",
            "quiet dq/dm", DW'({dq_rise, dq_fall, dm_rise, dm_fall}), '0);
        if (exp_dv[nx])
          chk(dqs_oe == 2'b11 && dqs_lvl == 2'b00, "R6", "dqs preamble",
              DW'({dqs_oe, dqs_lvl}), DW'(4'b1100));
        else if (exp_dv[pv])
          chk(dqs_oe == 2'b01 && dqs_lvl == 2'b00, "R7", "dqs postamble",
              DW'({dqs_oe, dqs_lvl}), DW'(4'b0100));
        else
          chk(dqs_oe == 2'b00, "R7", "dqs released", DW'(dqs_oe), '0);
      end

      if (cmd_fire && qn > 0) begin
        req_t h;
        bit b;
        h = q.pop_front();
        b = (m_bl == 0) ? 1'b0 : (m_bl == 1) ? 1'b1 : h.bc4;
        chk(cmd_bc4 == b, "R10", "cmd_bc4", DW'(cmd_bc4), DW'(b));
        for (int i = 0; i < (b ? 2 : 4); i++) begin
          int t;
          t = (cyc + 1 + m_wl + i) % 64;   // R2 latency, R3 alignment
          exp_dv[t] = 1;
          exp_r[t]  = h.d[(2*i)*DQ_W +: DQ_W];
          exp_f[t]  = h.d[(2*i+1)*DQ_W +: DQ_W];
          exp_mr[t] = h.m[(2*i)*MW +: MW];
          exp_mf[t] = h.m[(2*i+1)*MW +: MW];
        end
        last_fire = cyc;
      end
      if (in_valid && in_ready) q.push_back('{d: in_data, m: in_mask, bc4: in_bc4});
      if (idle) begin
        m_wl = model_wl(cfg_al_sel, cfg_cl, cfg_cwl);
        m_bl = int'(cfg_bl_sel);
      end
      exp_dv[(cyc + 62) % 64] = 0;
      cyc++;
    end
  end

  task automatic push_req(bit bc4);
    in_valid = 1'b1;
    in_bc4   = bc4;
    in_data  = {$urandom, $urandom, $urandom, $urandom};
    in_mask  = 16'($urandom);
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_cfg(logic [1:0] al, logic [3:0] cl, logic [3:0] cwl, logic [1:0] bl);
    cfg_al_sel = al; cfg_cl = cl; cfg_cwl = cwl; cfg_bl_sel = bl;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errs++;
      $display("FAIL R11 watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) exp_dv[i] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(in_ready == 1'b1, "R1", "in_ready in reset", DW'(in_ready), DW'(1));
    chk(cmd_fire == 1'b0, "R1", "cmd_fire in reset", DW'(cmd_fire), '0);
    chk(dq_oe == 1'b0 && dqs_oe == 2'b00, "R1", "oe in reset", DW'({dq_oe, dqs_oe}), '0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    started = 1;
    wait_cyc(4);

    // R3 single eight-beat burst, WL 5
    push_req(0);
    wait_cyc(20);
    // R9 chained eight-beat bursts
    repeat (3) push_req(0);
    wait_cyc(25);
    // R10 fixed four-beat
    set_cfg(2'd0, 4'd6, 4'd6, 2'd1);
    wait_cyc(3);
    repeat (3) push_req(0);
    wait_cyc(25);
    // R10 per request, R12 back-pressure
    set_cfg(2'd0, 4'd6, 4'd7, 2'd2);
    wait_cyc(3);
    for (int i = 0; i < 8; i++) push_req(i[0]);
    wait_cyc(30);
    // R6/R7 gaps of several sizes
    for (int w = 0; w < 7; w++) begin
      push_req(w[1]);
      wait_cyc(w);
    end
    wait_cyc(30);
    // R2 settings change while busy is deferred
    push_req(0);
    set_cfg(2'd1, 4'd11, 4'd8, 2'd0);
    push_req(0);
    wait_cyc(35);
    push_req(0);
    push_req(0);
    wait_cyc(40);
    // R2 AL = CL-2
    set_cfg(2'd2, 4'd7, 4'd6, 2'd3);
    wait_cyc(3);
    for (int i = 0; i < 5; i++) push_req(i == 2);
    wait_cyc(35);
    // R2 spare AL select acts as zero
    set_cfg(2'd3, 4'd9, 4'd8, 2'd0);
    wait_cyc(3);
    push_req(0);
    wait_cyc(30);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule